// File: doc/BRIEF.md
# Privileged Control Register Write Legalizer

This block keeps four privileged control registers of a small core: a status word, the machine and supervisor trap-vector bases, and the address-translation pointer. Each register is its own storage element. A requester presents one access at a time. An access carries a register select, a read or write indication, write data and the current privilege level. Every write passes through a per-register filter before it is stored.

The filters work as follows:

- **Status:** only a fixed set of writable bits can change.
- **Trap vectors:** a write that names a reserved mode is dropped in full.
- **Translation pointer:** a write is refused when the requester runs at supervisor level while the status word's trap-virtual-memory bit is set.

The block reports two one-cycle pulses on the clock edge that stores a write. An illegal pulse marks a refused translation-pointer write. A flush pulse tells the translation cache that fields affecting address translation have changed.

Reads are combinational. The selected register appears on the read bus in the same cycle as the select.

Top module: `csr_legalizer`

## Requirements
- R1: After reset, all four registers read as zero (both trap vectors in direct mode), and the flush and illegal outputs are low.
- R2: A trap-vector write whose bits [1:0] are 0 (direct) or 1 (vectored) stores the full written value, mode bits included, on the next clock edge. Select 1 is the machine vector and select 2 is the supervisor vector.
- R3: A trap-vector write whose bits [1:0] are 2 or 3 leaves the register unchanged and raises neither flush nor illegal.
- R4: A write to the translation pointer (select 3) at supervisor privilege (encoding 1) while status bit 20 is set is refused. Illegal pulses on the next cycle, the pointer keeps its old value, and no flush is raised.
- R5: An accepted translation-pointer write is stored on the next edge. It pulses flush only when the address-space-ID field (bits 30:22) of the new value differs from the old one. Machine (3) and user (0) privilege writes are never refused.
- R6: A status write (select 0) changes only the writable bits, which are 1, 3, 5, 7, 8, 11 through 14, and 17 through 22 (mask 0x007E79AA). Every other bit keeps its old value.
- R7: A status write pulses flush when any of bits 11, 12, 17, 18 or 19 changes value. A change confined to other bits raises no flush.
- R8: The read bus shows the register chosen by the select in the same cycle. A read (write indication low) changes no register and raises no flag.
- R9: The flush and illegal outputs are registered. Each stays high for exactly one cycle per causing request and returns low after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 status, 1 machine vector, 2 supervisor vector, 3 translation pointer |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_wdata | input | XLEN | Write data |
| rd_data | output | XLEN | Selected register contents (combinational) |
| flush_o | output | 1 | One-cycle translation-cache flush request |
| illegal_o | output | 1 | One-cycle illegal-access flag |

## Verification
Every cycle, assertions check the following:

- A reserved-mode vector write leaves its register untouched.
- A legal vector write stores exactly the written word.
- Status writes never alter non-writable bits.
- A refused pointer write leaves the pointer stable and raises illegal.
- Flush and illegal pulses only follow a write that could cause them.
- Reads never raise illegal.

Only the bench scenarios can show the rest:

- The exact flush decision for each field combination, such as an unchanged address-space ID or a change confined to non-translation bits.
- That the stored values accumulate correctly across a sequence of writes.
- That the guard on the pointer depends on privilege.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;

    // register select encoding
    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_MTVEC  = 2'd1;
    localparam logic [1:0] SEL_STVEC  = 2'd2;
    localparam logic [1:0] SEL_XLAT   = 2'd3;

    // privilege encoding
    localparam logic [1:0] PRIV_USER    = 2'd0;
    localparam logic [1:0] PRIV_SUPER   = 2'd1;
    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    // trap-vector modes
    localparam logic [1:0] TV_DIRECT   = 2'd0;
    localparam logic [1:0] TV_VECTORED = 2'd1;

    // status bit positions
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_FS_LO  = 13;
    localparam int ST_MPRV   = 17;
    localparam int ST_SUM    = 18;
    localparam int ST_MXR    = 19;
    localparam int ST_TVM    = 20;
    localparam int ST_TW     = 21;
    localparam int ST_TSR    = 22;

    localparam logic [63:0] ONE64 = 64'd1;

    // bits software may change in the status word
    localparam logic [63:0] ST_WR_MASK64 =
        (ONE64 << ST_SIE)  | (ONE64 << ST_MIE)  | (ONE64 << ST_SPIE) |
        (ONE64 << ST_MPIE) | (ONE64 << ST_SPP)  |
        (ONE64 << ST_MPP_LO) | (ONE64 << (ST_MPP_LO + 1)) |
        (ONE64 << ST_FS_LO)  | (ONE64 << (ST_FS_LO + 1))  |
        (ONE64 << ST_MPRV) | (ONE64 << ST_SUM)  | (ONE64 << ST_MXR) |
        (ONE64 << ST_TVM)  | (ONE64 << ST_TW)   | (ONE64 << ST_TSR);

    // status bits whose change invalidates cached translations
    localparam logic [63:0] ST_XLAT_MASK64 =
        (ONE64 << ST_MPP_LO) | (ONE64 << (ST_MPP_LO + 1)) |
        (ONE64 << ST_MPRV) | (ONE64 << ST_SUM) | (ONE64 << ST_MXR);

    function automatic logic tvec_mode_ok(input logic [1:0] mode);
        return (mode == TV_DIRECT) || (mode == TV_VECTORED);
    endfunction

endpackage

// File: rtl/tvec_legal.sv
module tvec_legal
    import csr_legal_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            wr_en,
    input  logic [XLEN-1:0] cur_q,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] next_d,
    output logic            taken
);

    always_comb begin
        taken  = wr_en && tvec_mode_ok(wdata[1:0]);
        next_d = taken ? wdata : cur_q;
    end

endmodule

// File: rtl/status_merge.sv
module status_merge
    import csr_legal_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            wr_en,
    input  logic [XLEN-1:0] cur_q,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] next_d,
    output logic            xlat_touch
);

    localparam logic [XLEN-1:0] WR_MASK   = XLEN'(ST_WR_MASK64);
    localparam logic [XLEN-1:0] XLAT_MASK = XLEN'(ST_XLAT_MASK64);

    logic [XLEN-1:0] merged;

    always_comb begin
        merged     = (cur_q & ~WR_MASK) | (wdata & WR_MASK);
        next_d     = wr_en ? merged : cur_q;
        xlat_touch = wr_en && (((merged ^ cur_q) & XLAT_MASK) != '0);
    end

endmodule

// File: rtl/xlat_gate.sv
module xlat_gate
    import csr_legal_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int ASID_LSB = 22,
    parameter int ASID_W   = 9
) (
    input  logic            wr_en,
    input  logic [1:0]      priv,
    input  logic            tvm,
    input  logic [XLEN-1:0] cur_q,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] next_d,
    output logic            refuse,
    output logic            asid_flip
);

    localparam int ASID_MSB = ASID_LSB + ASID_W - 1;

    logic accept;

    always_comb begin
        refuse    = wr_en && (priv == PRIV_SUPER) && tvm;
        accept    = wr_en && !refuse;
        next_d    = accept ? wdata : cur_q;
        asid_flip = accept && (wdata[ASID_MSB:ASID_LSB] != cur_q[ASID_MSB:ASID_LSB]);
    end

endmodule

// File: rtl/csr_legalizer.sv
module csr_legalizer
    import csr_legal_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int ASID_LSB = 22,
    parameter int ASID_W   = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_sel,
    input  logic [1:0]      req_priv,
    input  logic [XLEN-1:0] req_wdata,
    output logic [XLEN-1:0] rd_data,
    output logic            flush_o,
    output logic            illegal_o
);

    localparam int               NUM_TVEC = 2;
    localparam logic [XLEN-1:0]  WR_MASK  = XLEN'(ST_WR_MASK64);

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] mtvec;
        logic [XLEN-1:0] stvec;
        logic [XLEN-1:0] xlat;
        logic            flush;
        logic            illegal;
    } state_t;

    state_t state_d, state_q;

    logic            is_wr;
    logic            st_we, xl_we;
    logic [XLEN-1:0] status_nx, xlat_nx;
    logic            st_touch, xl_refuse, xl_flip;

    logic [NUM_TVEC-1:0]            tv_we;
    logic [NUM_TVEC-1:0]            tv_taken;
    logic [NUM_TVEC-1:0][XLEN-1:0]  tv_cur;
    logic [NUM_TVEC-1:0][XLEN-1:0]  tv_nx;

    always_comb begin
        is_wr    = req_valid && req_write;
        st_we    = is_wr && (req_sel == SEL_STATUS);
        xl_we    = is_wr && (req_sel == SEL_XLAT);
        tv_we[0] = is_wr && (req_sel == SEL_MTVEC);
        tv_we[1] = is_wr && (req_sel == SEL_STVEC);
        tv_cur[0] = state_q.mtvec;
        tv_cur[1] = state_q.stvec;
    end

    status_merge #(.XLEN(XLEN)) u_status (
        .wr_en      (st_we),
        .cur_q      (state_q.status),
        .wdata      (req_wdata),
        .next_d     (status_nx),
        .xlat_touch (st_touch)
    );

    for (genvar gi = 0; gi < NUM_TVEC; gi++) begin : g_tvec
        tvec_legal #(.XLEN(XLEN)) u_tvec (
            .wr_en  (tv_we[gi]),
            .cur_q  (tv_cur[gi]),
            .wdata  (req_wdata),
            .next_d (tv_nx[gi]),
            .taken  (tv_taken[gi])
        );
    end

    xlat_gate #(.XLEN(XLEN), .ASID_LSB(ASID_LSB), .ASID_W(ASID_W)) u_xlat (
        .wr_en     (xl_we),
        .priv      (req_priv),
        .tvm       (state_q.status[ST_TVM]),
        .cur_q     (state_q.xlat),
        .wdata     (req_wdata),
        .next_d    (xlat_nx),
        .refuse    (xl_refuse),
        .asid_flip (xl_flip)
    );

    always_comb begin
        state_d         = state_q;
        state_d.status  = status_nx;
        state_d.mtvec   = tv_nx[0];
        state_d.stvec   = tv_nx[1];
        state_d.xlat    = xlat_nx;
        state_d.flush   = st_touch || xl_flip;
        state_d.illegal = xl_refuse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (req_sel)
            SEL_STATUS: rd_data = state_q.status;
            SEL_MTVEC:  rd_data = state_q.mtvec;
            SEL_STVEC:  rd_data = state_q.stvec;
            default:    rd_data = state_q.xlat;
        endcase
    end

    assign flush_o   = state_q.flush;
    assign illegal_o = state_q.illegal;

    // R2: a legal-mode vector write stores the written word
    a_r2_mtvec_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == SEL_MTVEC && req_wdata[1:0] < 2'd2)
        |=> (state_q.mtvec == $past(req_wdata)));

    // R3: reserved-mode vector writes leave the registers alone
    a_r3_mtvec_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == SEL_MTVEC && req_wdata[1:0] >= 2'd2)
        |=> $stable(state_q.mtvec));
    a_r3_stvec_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == SEL_STVEC && req_wdata[1:0] >= 2'd2)
        |=> $stable(state_q.stvec));

    // R4: refused pointer write flags illegal and keeps the pointer
    a_r4_xlat_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == SEL_XLAT &&
         req_priv == PRIV_SUPER && state_q.status[ST_TVM])
        |=> (illegal_o && $stable(state_q.xlat) && !flush_o));

    // R6: non-writable status bits never move
    a_r6_status_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == SEL_STATUS)
        |=> (((state_q.status ^ $past(state_q.status)) & ~WR_MASK) == '0));

    // R7 / R5: a flush only follows a status or pointer write
    a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(req_valid && req_write &&
                          (req_sel == SEL_STATUS || req_sel == SEL_XLAT)));

    // R9: illegal only follows a pointer write
    a_r9_illegal_cause: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(req_valid && req_write && req_sel == SEL_XLAT));

    // R8: reads never raise illegal
    a_r8_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !illegal_o);

endmodule

// File: tb/sim_csr_legalizer.sv
module sim_csr_legalizer;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NVEC = 17;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  sel;
        logic        wr;
        logic [1:0]  priv;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_flush;
        logic        exp_ill;
    } vec_t;

    // sel: 0 status, 1 mvec, 2 svec, 3 pointer; priv: 0 U, 1 S, 3 M
    localparam vec_t VECS [NVEC] = '{
        '{4'd6, 2'd0, 1'b1, 2'd3, 32'hFFFF_FFFF, 32'h007E_79AA, 1'b1, 1'b0}, // R6 R7
        '{4'd7, 2'd0, 1'b1, 2'd3, 32'h0000_0002, 32'h0000_0002, 1'b1, 1'b0}, // R7
        '{4'd7, 2'd0, 1'b1, 2'd3, 32'h0000_000A, 32'h0000_000A, 1'b0, 1'b0}, // R7
        '{4'd7, 2'd0, 1'b1, 2'd3, 32'h0000_1808, 32'h0000_1808, 1'b1, 1'b0}, // R7
        '{4'd6, 2'd0, 1'b1, 2'd3, 32'h8000_1808, 32'h0000_1808, 1'b0, 1'b0}, // R6
        '{4'd2, 2'd1, 1'b1, 2'd3, 32'h8000_0101, 32'h8000_0101, 1'b0, 1'b0}, // R2
        '{4'd3, 2'd1, 1'b1, 2'd3, 32'h1234_5672, 32'h8000_0101, 1'b0, 1'b0}, // R3
        '{4'd3, 2'd1, 1'b1, 2'd3, 32'h1234_5673, 32'h8000_0101, 1'b0, 1'b0}, // R3
        '{4'd2, 2'd2, 1'b1, 2'd1, 32'h4000_0200, 32'h4000_0200, 1'b0, 1'b0}, // R2
        '{4'd3, 2'd2, 1'b1, 2'd1, 32'h4000_0203, 32'h4000_0200, 1'b0, 1'b0}, // R3
        '{4'd5, 2'd3, 1'b1, 2'd1, 32'h8040_0010, 32'h8040_0010, 1'b1, 1'b0}, // R5
        '{4'd5, 2'd3, 1'b1, 2'd1, 32'h8040_0020, 32'h8040_0020, 1'b0, 1'b0}, // R5
        '{4'd6, 2'd0, 1'b1, 2'd3, 32'h0010_1808, 32'h0010_1808, 1'b0, 1'b0}, // R6
        '{4'd4, 2'd3, 1'b1, 2'd1, 32'h0000_0000, 32'h8040_0020, 1'b0, 1'b1}, // R4
        '{4'd5, 2'd3, 1'b1, 2'd3, 32'h0080_0020, 32'h0080_0020, 1'b1, 1'b0}, // R5
        '{4'd5, 2'd3, 1'b1, 2'd0, 32'h0080_0030, 32'h0080_0030, 1'b0, 1'b0}, // R5
        '{4'd8, 2'd0, 1'b0, 2'd3, 32'hFFFF_FFFF, 32'h0010_1808, 1'b0, 1'b0}  // R8
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [1:0]      req_sel = 2'd0;
    logic [1:0]      req_priv = 2'd3;
    logic [XLEN-1:0] req_wdata = '0;
    logic [XLEN-1:0] rd_data;
    logic            flush_o;
    logic            illegal_o;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_legalizer #(.XLEN(XLEN)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (req_sel),
        .req_priv  (req_priv),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .flush_o   (flush_o),
        .illegal_o (illegal_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_sel(input logic [1:0] sel, output logic [31:0] val);
        req_sel = sel;
        #1;
        val = rd_data;
    endtask

    // drive one request, sample pulses after the storing edge, then read back
    task automatic apply(input logic [1:0] sel, input logic wr, input logic [1:0] pv,
                         input logic [31:0] d, output logic fl, output logic il,
                         output logic [31:0] rb);
        req_valid = 1'b1;
        req_write = wr;
        req_sel   = sel;
        req_priv  = pv;
        req_wdata = d;
        @(negedge clk);
        fl = flush_o;
        il = illegal_o;
        req_valid = 1'b0;
        req_write = 1'b0;
        read_sel(sel, rb);
    endtask

    initial begin
        logic        fl, il;
        logic [31:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            read_sel(2'(s), rb);
            check($sformatf("R1 reg%0d after reset", s), rb, 32'h0);
        end
        check("R1 flush after reset", {31'b0, flush_o}, 32'h0);
        check("R1 illegal after reset", {31'b0, illegal_o}, 32'h0);
        @(negedge clk);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].sel, VECS[i].wr, VECS[i].priv, VECS[i].wdata, fl, il, rb);
            check($sformatf("R%0d vec%0d readback", VECS[i].req, i), rb, VECS[i].exp_rd);
            check($sformatf("R%0d vec%0d flush", VECS[i].req, i), {31'b0, fl}, {31'b0, VECS[i].exp_flush});
            check($sformatf("R%0d vec%0d illegal", VECS[i].req, i), {31'b0, il}, {31'b0, VECS[i].exp_ill});
        end

        // R8: same-cycle read of the machine vector, nothing changes
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_sel   = 2'd1;
        #1;
        check("R8 same-cycle read", rd_data, 32'h8000_0101);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 read keeps value", rd_data, 32'h8000_0101);
        check("R8 read no illegal", {31'b0, illegal_o}, 32'h0);

        // R9: pulses last one cycle; refused pointer write then idle
        apply(2'd3, 1'b1, 2'd1, 32'h7FC0_0000, fl, il, rb);
        check("R9 illegal high", {31'b0, il}, 32'h1);
        check("R4 pointer kept", rb, 32'h0080_0030);
        @(negedge clk);
        check("R9 illegal back low", {31'b0, illegal_o}, 32'h0);
        apply(2'd0, 1'b1, 2'd3, 32'h0008_0000, fl, il, rb);
        check("R7 MXR change flush", {31'b0, fl}, 32'h1);
        check("R6 status merge", rb, 32'h0008_0000);
        @(negedge clk);
        check("R9 flush back low", {31'b0, flush_o}, 32'h0);

        // R4 boundary: TVM now clear, supervisor write accepted
        apply(2'd3, 1'b1, 2'd1, 32'h0080_0031, fl, il, rb);
        check("R5 supervisor accepted when TVM clear", rb, 32'h0080_0031);
        check("R5 no illegal", {31'b0, il}, 32'h0);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            read_sel(2'(s), rb);
            check($sformatf("R1 reg%0d after re-reset", s), rb, 32'h0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule